// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

A memory-mapped watchdog that counts down in two stages. Software loads a preload value for each stage and issues a restart command. When the first stage runs out, the block can raise an interrupt and then starts the second stage. When the second stage runs out, it sets a sticky timeout flag and can request a system reset through a fixed-width pulse. Software that is still alive restarts the countdown before this happens.

The preload registers and the restart/status register are guarded. A two-write key must precede each guarded write, and one key admits exactly one guarded write. A configuration register selects the tick rate, the interrupt behaviour and whether the reset request is driven. A control register enables counting, picks watchdog or plain periodic-timer mode, and holds a lock bit that keeps the timer from being switched off until the next reset.

The key handler is a state machine with states UL_SHUT, UL_HALF and UL_OPEN. UL_SHUT goes to UL_HALF on a first-key write. UL_HALF goes to UL_OPEN on a second-key write and falls back to UL_SHUT on any other write to the restart register. UL_OPEN goes back to UL_SHUT on any guarded write. The countdown is a second state machine with states PH_IDLE, PH_ONE, PH_TWO and PH_DONE. Any state goes to PH_ONE on a restart. PH_ONE goes to PH_TWO on first-stage expiry, or reloads itself in timer mode. PH_TWO goes to PH_DONE on second-stage expiry. PH_DONE and PH_IDLE wait for a restart.

Top module: `wdog_twostage`

Word addresses on `bus_waddr`: 0 = stage-one preload, 1 = stage-two preload, 2 = interrupt status, 3 = restart/status, 4 = configuration, 5 = control. Any other address reads as zero.

## Requirements
- R1: Writes to addresses 0, 1 and 3 take effect only while the key handler is in UL_OPEN. UL_OPEN is reached by writing 0x0080 and then 0x0086 in bits 15:0 to address 3. Each guarded write, whether accepted or not, returns the handler to UL_SHUT. Unaccepted guarded writes leave the registers unchanged.
- R2: In UL_HALF, a write to address 3 whose bits 15:0 are not 0x0086 returns the handler to UL_SHUT, so the following guarded write is ignored.
- R3: The preloads are 20 bits wide and bits 31:20 read as zero. A preload of 0 counts as 1.
- R4: An accepted write to address 3 with bit 8 set loads the stage-one count from the preload at address 0 and enters PH_ONE. The count expires on the Nth tick after loading, where N is the preload value.
- R5: The tick comes from a free-running 15-bit prescaler that starts at zero after reset. With configuration bit 2 clear, a tick occurs once every 32768 clocks. With bit 2 set, a tick occurs once every 32 clocks, whenever the low 5 bits of the prescaler are all ones.
- R6: On stage-one expiry, if configuration bits 1:0 are not 3, bit 0 at address 2 is set and `irq` goes high. It stays high until a write with bit 0 set to address 2. After reset, configuration bits 1:0 are 3.
- R7: In watchdog mode, stage-one expiry loads the stage-two count from the preload at address 1. When that count expires, the timeout flag is set. If configuration bit 5 is 0, `rst_req` is also high for exactly 16 clocks.
- R8: The timeout flag reads at bit 9 of address 3. It is cleared only by an accepted write to address 3 with bit 9 set.
- R9: Control bit 1 enables counting. While it is 0, the count and stage hold their values. Control bit 0 is the lock bit: once set, neither the lock bit nor the enable bit can be cleared, and control bit 2 cannot be changed.
- R10: With control bit 2 set (timer mode), stage-one expiry reloads stage one from the preload at address 0. The block does not enter stage two, and `rst_req` stays low.
- R11: Writes honour `bus_be`: a register byte whose enable is 0 keeps its value, and key or command bits in a disabled byte read as 0. Only bits 5, 2 and 1:0 of the configuration register are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_waddr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| irq | output | 1 | Stage-one interrupt level |
| rst_req | output | 1 | Reset request pulse |

## Verification
If the key state is wrong, the error shows on the next guarded write: the preload readback either changes when it should not, or fails to change. If the count or the stage is off by one, `irq` or `rst_req` rises one tick early or late, which in fast mode is 32 clocks. If the prescaler is wrong, the first expiry moves by a whole tick period. Because these effects show up at the pins within a tick, a model that is compared on every clock catches each of them in the cycle where the pins first disagree.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_ONE, PH_TWO, PH_DONE} phase_t;
    typedef enum logic [1:0] {UL_SHUT, UL_HALF, UL_OPEN} key_t;

    localparam logic [2:0] A_PRE1   = 3'd0;
    localparam logic [2:0] A_PRE2   = 3'd1;
    localparam logic [2:0] A_ISTAT  = 3'd2;
    localparam logic [2:0] A_RELOAD = 3'd3;
    localparam logic [2:0] A_CFG    = 3'd4;
    localparam logic [2:0] A_CTRL   = 3'd5;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;
    localparam logic [5:0]  CFG_KEEP   = 6'h27;
    localparam logic [5:0]  CFG_RESET  = 6'h03;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
    parameter int SLOW_W = 15,
    parameter int FAST_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    logic [SLOW_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + SLOW_W'(1);
    end

    assign tick = fast ? (&div_q[FAST_W-1:0]) : (&div_q);
endmodule

// File: rtl/wdt2_keyfsm.sv
module wdt2_keyfsm
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [15:0] key_data,
    input  logic        guard_wr,
    output logic        open
);
    key_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_SHUT: if (key_wr && key_data == KEY_FIRST) state_d = UL_HALF;
            UL_HALF: if (key_wr) state_d = (key_data == KEY_SECOND) ? UL_OPEN : UL_SHUT;
            UL_OPEN: if (guard_wr) state_d = UL_SHUT;
            default: state_d = UL_SHUT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            UL_OPEN: open = 1'b1;
            default: open = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
    import wdt2_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             timer_mode,
    input  logic             restart,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic             exp1,
    output logic             exp2
);
    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ld1, ld2;
    logic             last, step;

    assign ld1  = (pre1 == '0) ? CNT_W'(1) : pre1;
    assign ld2  = (pre2 == '0) ? CNT_W'(1) : pre2;
    assign last = (cnt_q == CNT_W'(1));
    assign step = tick && run && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (restart) begin
            phase_d = PH_ONE;
            cnt_d   = ld1;
        end else if (step) begin
            unique case (phase_q)
                PH_ONE: begin
                    if (!last)           cnt_d = cnt_q - CNT_W'(1);
                    else if (timer_mode) cnt_d = ld1;
                    else begin
                        phase_d = PH_TWO;
                        cnt_d   = ld2;
                    end
                end
                PH_TWO: begin
                    if (!last) cnt_d = cnt_q - CNT_W'(1);
                    else       phase_d = PH_DONE;
                end
                PH_IDLE, PH_DONE: ;
            endcase
        end
    end

    always_comb begin
        exp1 = 1'b0;
        exp2 = 1'b0;
        unique case (phase_q)
            PH_ONE:           exp1 = step && last;
            PH_TWO:           exp2 = step && last;
            PH_IDLE, PH_DONE: ;
        endcase
    end
endmodule

// File: rtl/wdt2_pulse.sv
module wdt2_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= CW'(LEN);
        else if (left_q != '0)   left_q <= left_q - CW'(1);
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdt2_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int SLOW_W  = 15,
    parameter int FAST_W  = 5,
    parameter int RST_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_waddr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        rst_req
);
    logic [31:0]      lane_mask, wd_eff;
    logic             guard_wr, key_wr, key_open, guard_ok;
    logic             restart, to_clr, ist_clr;
    logic [CNT_W-1:0] pre1_q, pre2_q;
    logic [5:0]       cfg_q;
    logic             lk_lock_q, lk_en_q, lk_mode_q;
    logic             ist_q, to_flag_q;
    logic             tick, exp1, exp2;
    logic             unused_wd;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
    end

    assign wd_eff    = bus_wdata & lane_mask;
    assign unused_wd = ^wd_eff;
    assign guard_wr  = bus_we && (bus_waddr == A_PRE1 || bus_waddr == A_PRE2 ||
                                  bus_waddr == A_RELOAD);
    assign key_wr    = bus_we && bus_waddr == A_RELOAD;
    assign guard_ok  = guard_wr && key_open;
    assign restart   = guard_ok && bus_waddr == A_RELOAD && wd_eff[8];
    assign to_clr    = guard_ok && bus_waddr == A_RELOAD && wd_eff[9];
    assign ist_clr   = bus_we && bus_waddr == A_ISTAT && wd_eff[0];

    wdt2_keyfsm u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wd_eff[15:0]),
        .guard_wr(guard_wr), .open(key_open)
    );

    wdt2_prescaler #(.SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .fast(cfg_q[2]), .tick(tick)
    );

    wdt2_countdown #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(lk_en_q),
        .timer_mode(lk_mode_q), .restart(restart), .pre1(pre1_q),
        .pre2(pre2_q), .exp1(exp1), .exp2(exp2)
    );

    wdt2_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(exp2 && !cfg_q[5]), .active(rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre1_q    <= '0;
            pre2_q    <= '0;
            cfg_q     <= CFG_RESET;
            lk_lock_q <= 1'b0;
            lk_en_q   <= 1'b0;
            lk_mode_q <= 1'b0;
            ist_q     <= 1'b0;
            to_flag_q <= 1'b0;
        end else begin
            if (guard_ok && bus_waddr == A_PRE1)
                pre1_q <= (pre1_q & ~lane_mask[CNT_W-1:0]) | wd_eff[CNT_W-1:0];
            if (guard_ok && bus_waddr == A_PRE2)
                pre2_q <= (pre2_q & ~lane_mask[CNT_W-1:0]) | wd_eff[CNT_W-1:0];
            if (bus_we && bus_waddr == A_CFG)
                cfg_q <= ((cfg_q & ~lane_mask[5:0]) | wd_eff[5:0]) & CFG_KEEP;
            if (bus_we && bus_waddr == A_CTRL && bus_be[0]) begin
                if (lk_lock_q) begin
                    lk_en_q <= lk_en_q | wd_eff[1];
                end else begin
                    lk_lock_q <= wd_eff[0];
                    lk_en_q   <= wd_eff[1];
                    lk_mode_q <= wd_eff[2];
                end
            end
            if (exp1 && cfg_q[1:0] != 2'b11) ist_q <= 1'b1;
            else if (ist_clr)                ist_q <= 1'b0;
            if (exp2)        to_flag_q <= 1'b1;
            else if (to_clr) to_flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_waddr)
            A_PRE1:   bus_rdata[CNT_W-1:0] = pre1_q;
            A_PRE2:   bus_rdata[CNT_W-1:0] = pre2_q;
            A_ISTAT:  bus_rdata[0] = ist_q;
            A_RELOAD: bus_rdata[9] = to_flag_q;
            A_CFG:    bus_rdata[5:0] = cfg_q;
            A_CTRL:   bus_rdata[2:0] = {lk_mode_q, lk_en_q, lk_lock_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ist_q;
endmodule

// File: rtl/wdt2_chk.sv
module wdt2_chk #(
    parameter int CNT_W   = 20,
    parameter int RST_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             irq,
    input logic             to_flag,
    input logic             lk_lock,
    input logic             lk_en,
    input logic             key_open,
    input logic             guard_wr,
    input logic             ist_clr,
    input logic [CNT_W-1:0] pre1
);
    localparam int HW = $clog2(RST_LEN + 2);
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_q <= '0;
        else if (rst_req) hi_q <= hi_q + HW'(1);
        else              hi_q <= '0;
    end

    AST_PRE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !key_open |=> $stable(pre1)); // R1
    AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        key_open && guard_wr |=> !key_open); // R1
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ist_clr |=> irq); // R6
    AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> to_flag); // R7
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> hi_q == HW'(RST_LEN)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_lock |=> lk_lock); // R9
    AST_EN_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_lock && lk_en |=> lk_en); // R9
endmodule

bind wdog_twostage wdt2_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq), .to_flag(to_flag_q),
    .lk_lock(lk_lock_q), .lk_en(lk_en_q), .key_open(key_open),
    .guard_wr(guard_wr), .ist_clr(ist_clr), .pre1(pre1_q)
);

// File: tb/test_wdog_twostage.sv
`timescale 1ns/100ps
module test_wdog_twostage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_waddr = 3'd0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    wdog_twostage i_wdog_twostage (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_p1, m_p2, m_cfg, m_lk;
    int m_key, m_ph, m_cnt, m_to, m_is, m_rc;
    longint m_ps;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_p1;
            3'd1: return m_p2;
            3'd2: return 32'(m_is);
            3'd3: return m_to != 0 ? 32'h200 : 32'h0;
            3'd4: return m_cfg;
            3'd5: return m_lk;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string m_tag(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R3";
            3'd2: return "R6";
            3'd3: return "R8";
            3'd4: return "R11";
            3'd5: return "R9";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_cfg = 32'h3; m_lk = 0;
            m_key = 0; m_ph = 0; m_cnt = 0; m_to = 0; m_is = 0; m_rc = 0; m_ps = 0;
        end else begin
            logic [31:0] msk, d;
            bit tick, guard, ok, rl, e1, e2;
            int ld1, ld2;
            msk = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
            d = bus_wdata & msk;
            tick = m_cfg[2] ? (m_ps % 32 == 31) : (m_ps % 32768 == 32767);
            m_ps++;
            guard = bus_we && (bus_waddr == 0 || bus_waddr == 1 || bus_waddr == 3);
            ok = guard && m_key == 2;
            rl = ok && bus_waddr == 3 && d[8];
            ld1 = m_p1 == 0 ? 1 : int'(m_p1);
            ld2 = m_p2 == 0 ? 1 : int'(m_p2);
            e1 = 0; e2 = 0;
            if (m_key == 2 && guard) m_key = 0;
            else if (bus_we && bus_waddr == 3) begin
                if (m_key == 0) m_key = (d[15:0] == 16'h80) ? 1 : 0;
                else m_key = (d[15:0] == 16'h86) ? 2 : 0;
            end
            if (rl) begin m_ph = 1; m_cnt = ld1; end
            else if (tick && m_lk[1]) begin
                if (m_ph == 1) begin
                    if (m_cnt > 1) m_cnt--;
                    else begin
                        e1 = 1;
                        if (m_lk[2]) m_cnt = ld1;
                        else begin m_ph = 2; m_cnt = ld2; end
                    end
                end else if (m_ph == 2) begin
                    if (m_cnt > 1) m_cnt--;
                    else begin e2 = 1; m_ph = 3; end
                end
            end
            if (e1 && m_cfg[1:0] != 2'b11) m_is = 1;
            else if (bus_we && bus_waddr == 2 && d[0]) m_is = 0;
            if (e2) m_to = 1;
            else if (ok && bus_waddr == 3 && d[9]) m_to = 0;
            if (e2 && !m_cfg[5]) m_rc = 16;
            else if (m_rc > 0) m_rc--;
            if (ok && bus_waddr == 0) m_p1 = ((m_p1 & ~msk) | d) & 32'hFFFFF;
            if (ok && bus_waddr == 1) m_p2 = ((m_p2 & ~msk) | d) & 32'hFFFFF;
            if (bus_we && bus_waddr == 4) m_cfg = ((m_cfg & ~msk) | d) & 32'h27;
            if (bus_we && bus_waddr == 5 && bus_be[0]) begin
                if (m_lk[0]) m_lk = m_lk | (d & 32'h2);
                else m_lk = d & 32'h7;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R6 irq", 32'(irq), 32'(m_is));
            chk("R7 rst_req", 32'(rst_req), 32'(m_rc > 0));
            chk(m_tag(bus_waddr), bus_rdata, m_read(bus_waddr));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 190000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v, input logic [3:0] be = 4'hF);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_waddr = a; bus_wdata = v; bus_be = be;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic unlock();
        wr(3'd3, 32'h80);
        wr(3'd3, 32'h86);
    endtask

    task automatic gwr(input logic [2:0] a, input logic [31:0] v, input logic [3:0] be = 4'hF);
        unlock();
        wr(a, v, be);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_waddr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_hi(input bit which, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if ((which ? rst_req : irq) === 1'b1) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        #1 rst_n = 1'b1;
        rd(3'd4, v); chk("R6 config reset", v, 32'h3);
        rd(3'd0, v); chk("R3 preload reset", v, 32'h0);
        chk("R7 rst_req reset", 32'(rst_req), 32'h0);

        wr(3'd0, 32'h12345);
        rd(3'd0, v); chk("R1 write without key ignored", v, 32'h0);
        gwr(3'd0, 32'h12345);
        rd(3'd0, v); chk("R1 keyed write", v, 32'h12345);
        wr(3'd1, 32'h777);
        rd(3'd1, v); chk("R1 second write needs new key", v, 32'h0);
        wr(3'd3, 32'h80); wr(3'd3, 32'h55); wr(3'd3, 32'h86); wr(3'd1, 32'h99);
        rd(3'd1, v); chk("R2 broken key", v, 32'h0);
        gwr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R3 upper bits zero", v, 32'hFFFFF);
        gwr(3'd1, 32'h0000_03AB, 4'b0001);
        rd(3'd1, v); chk("R11 byte lane", v, 32'h0000_00AB);
        wr(3'd4, 32'hFFFF_FF00, 4'b0010);
        rd(3'd4, v); chk("R11 disabled lane", v, 32'h3);

        // watchdog run, fast ticks, irq type 0, reset enabled
        gwr(3'd0, 32'd3);
        gwr(3'd1, 32'd2);
        wr(3'd4, 32'h04);
        wr(3'd5, 32'h02);
        gwr(3'd3, 32'h100);
        wait_hi(0, 400);
        chk("R4 stage one expiry raises irq", 32'(irq), 32'h1);
        wait_hi(1, 400);
        chk("R7 reset request", 32'(rst_req), 32'h1);
        idle(20);
        rd(3'd3, v); chk("R7 timeout flag", v, 32'h200);
        wr(3'd2, 32'h1);
        rd(3'd2, v); chk("R6 status cleared", v, 32'h0);
        wr(3'd3, 32'h200);
        rd(3'd3, v); chk("R8 flag needs key", v, 32'h200);
        gwr(3'd3, 32'h200);
        rd(3'd3, v); chk("R8 flag cleared", v, 32'h0);

        // hold while disabled
        gwr(3'd0, 32'd5);
        gwr(3'd3, 32'h100);
        idle(70);
        wr(3'd5, 32'h00);
        idle(400);
        chk("R9 hold while disabled", 32'(irq), 32'h0);
        wr(3'd5, 32'h02);
        wait_hi(0, 300);
        chk("R9 resumes", 32'(irq), 32'h1);
        wr(3'd2, 32'h1);

        // zero preload, reset output disabled
        wr(3'd4, 32'h24);
        gwr(3'd0, 32'd0);
        gwr(3'd1, 32'd0);
        gwr(3'd3, 32'h100);
        wait_hi(0, 100);
        chk("R3 zero preload as one", 32'(irq), 32'h1);
        idle(100);
        rd(3'd3, v); chk("R7 flag without reset output", v, 32'h200);
        wr(3'd2, 32'h1);
        gwr(3'd3, 32'h300);

        // periodic timer mode
        wr(3'd4, 32'h04);
        gwr(3'd0, 32'd2);
        wr(3'd5, 32'h06);
        gwr(3'd3, 32'h100);
        wait_hi(0, 200);
        wr(3'd2, 32'h1);
        wait_hi(0, 200);
        chk("R10 stage one repeats", 32'(irq), 32'h1);
        idle(300);
        rd(3'd3, v); chk("R10 no stage two", v, 32'h0);
        wr(3'd2, 32'h1);

        // slow tick
        wr(3'd5, 32'h00);
        wr(3'd4, 32'h00);
        gwr(3'd0, 32'd1);
        wr(3'd5, 32'h02);
        gwr(3'd3, 32'h100);
        wait_hi(0, 33000);
        chk("R5 slow tick expiry", 32'(irq), 32'h1);
        wr(3'd2, 32'h1);

        // lock
        wr(3'd5, 32'h03);
        wr(3'd5, 32'h04);
        rd(3'd5, v); chk("R9 lock holds enable", v, 32'h3);
        idle(5);
        finish_run();
    end
endmodule